// File: doc/BRIEF.md
# Hardware-to-Software Streaming FIFO

This block carries data from hardware logic to software. Hardware offers words on a streaming push port, one per cycle, and software takes them by reading a single data offset on a simple register bus. Each successful data read removes the oldest word. A push and a pop may land in the same cycle.

Occupancy is held in a counter one bit wider than the pointer. Four flags are derived from it: full, empty, almost-full and almost-empty. Both almost thresholds are register fields that software can rewrite while traffic is flowing. A data read while nothing is stored gets an error response and no data. A push while the store is full is discarded and reported on a one-cycle overflow pulse. Everything runs on one clock.

Top module: `hwsw_fifo`

## Requirements
- R1: Depth is 2^DEPTH_LOG2 words and `count_o` is DEPTH_LOG2+1 bits wide. `full_o` is high exactly when the count equals the depth, and `empty_o` is high exactly when the count is zero. Flags and count show the state left by the most recent clock edge. After reset the count is 0, the almost-full threshold equals the depth and the almost-empty threshold is 0.
- R2: A push while not full stores `push_data_i`. Words leave in the order they were pushed.
- R3: A push while full is discarded and the stored words are unchanged. `overflow_o` is high for exactly the one cycle after the discarded push.
- R4: An accepted push and a pop in the same cycle leave the count unchanged. When the store is full, a simultaneous pop still proceeds, the push is discarded and the count drops by one.
- R5: `almost_full_o` is high when count >= the almost-full threshold, which is written through offset 0x4 (low DEPTH_LOG2+1 bits of the write data).
- R6: `almost_empty_o` is high when count <= the almost-empty threshold, which is written through offset 0x8 (low DEPTH_LOG2+1 bits of the write data).
- R7: A bus read of offset 0x0 while not empty pops the oldest word. One cycle later `bus_rsp_o` is high, `bus_err_o` is low and `bus_rdata_o` carries that word.
- R8: A bus read of offset 0x0 while empty gives a response with `bus_err_o` high and `bus_rdata_o` zero, and it changes no state.
- R9: A read of 0xC returns the status as it stood in the request cycle: bit 0 empty, bit 1 full, bit 2 almost-empty, bit 3 almost-full, bits [8+DEPTH_LOG2:8] the count, all other bits zero. Reads of 0x4 and 0x8 return the thresholds, zero-extended.
- R10: Every request gets exactly one response, with `bus_rsp_o` high for one cycle in the following cycle. A write to 0x0 and any access to an offset other than 0x0, 0x4, 0x8 or 0xC answer with `bus_err_o` high. A write to 0xC answers without error and has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| push_valid_i | input | 1 | Hardware push strobe |
| push_data_i | input | DATA_W | Word to push |
| overflow_o | output | 1 | Pulse: the previous cycle's push was discarded |
| full_o | output | 1 | No free entry |
| empty_o | output | 1 | No stored entry |
| almost_full_o | output | 1 | Count at or above the almost-full threshold |
| almost_empty_o | output | 1 | Count at or below the almost-empty threshold |
| count_o | output | DEPTH_LOG2+1 | Current occupancy |
| bus_req_i | input | 1 | Bus request strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 4 | Byte offset of the access |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rsp_o | output | 1 | Response valid, one cycle after the request |
| bus_err_o | output | 1 | Error response |
| bus_rdata_o | output | DATA_W | Read data, zero on writes and errors |

## Verification
On every cycle, the assertions check that full and empty are never high together, that the count stays within the depth, that a push at full yields an overflow pulse and leaves the count pinned, that a balanced push and pop holds the count, and that data reads get a clean or an error response according to the empty flag. Only the bench scenarios can show that the data comes out in order and unchanged after discarded pushes, that the thresholds take effect at their exact boundary counts, and that the status and threshold readback is correct.

// File: rtl/hwsw_fifo_pkg.sv
package hwsw_fifo_pkg;
  localparam int unsigned BUS_AW = 4;

  localparam logic [BUS_AW-1:0] OFS_DATA = 4'h0;
  localparam logic [BUS_AW-1:0] OFS_AF   = 4'h4;
  localparam logic [BUS_AW-1:0] OFS_AE   = 4'h8;
  localparam logic [BUS_AW-1:0] OFS_STAT = 4'hC;

  localparam int unsigned ST_EMPTY   = 0;
  localparam int unsigned ST_FULL    = 1;
  localparam int unsigned ST_AEMPTY  = 2;
  localparam int unsigned ST_AFULL   = 3;
  localparam int unsigned ST_CNT_LSB = 8;

  typedef struct packed {
    logic afull;
    logic aempty;
    logic full;
    logic empty;
  } occ_flags_t;
endpackage

// File: rtl/hwsw_fifo_store.sv
module hwsw_fifo_store #(
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          rd_en_i,
  output logic [DW-1:0] head_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else begin
      if (wr_en_i) wr_ptr_q <= wr_ptr_q + 1'b1;
      if (rd_en_i) rd_ptr_q <= rd_ptr_q + 1'b1;
    end
  end

  // storage is not reset; only pointers define validity
  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_ptr_q] <= wr_data_i;
  end

  assign head_o = mem_q[rd_ptr_q];
endmodule

// File: rtl/hwsw_fifo_occupancy.sv
module hwsw_fifo_occupancy
  import hwsw_fifo_pkg::*;
#(
  parameter int unsigned AW = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        push_i,
  input  logic        pop_i,
  input  logic [AW:0] af_thr_i,
  input  logic [AW:0] ae_thr_i,
  output logic [AW:0] count_o,
  output occ_flags_t  flags_o
);
  localparam int unsigned CW    = AW + 1;
  localparam int unsigned DEPTH = 1 << AW;

  logic [CW-1:0] count_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
    end else begin
      unique case ({push_i, pop_i})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: ;
      endcase
    end
  end

  always_comb begin
    flags_o.full   = (count_q == CW'(DEPTH));
    flags_o.empty  = (count_q == '0);
    flags_o.afull  = (count_q >= af_thr_i);
    flags_o.aempty = (count_q <= ae_thr_i);
  end

  assign count_o = count_q;
endmodule

// File: rtl/hwsw_fifo_regs.sv
module hwsw_fifo_regs
  import hwsw_fifo_pkg::*;
#(
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [BUS_AW-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  occ_flags_t        flags_i,
  input  logic [AW:0]       count_i,
  input  logic [DW-1:0]     head_i,
  output logic              pop_o,
  output logic [AW:0]       af_thr_o,
  output logic [AW:0]       ae_thr_o,
  output logic              rsp_o,
  output logic              err_o,
  output logic [DW-1:0]     rdata_o
);
  localparam int unsigned CW    = AW + 1;
  localparam int unsigned DEPTH = 1 << AW;

  logic [CW-1:0] af_q, ae_q;
  logic          rsp_q, err_q;
  logic [DW-1:0] rdata_q;
  logic          nx_err;
  logic [DW-1:0] nx_data;
  logic [DW-1:0] status;
  logic          unused_wdata_hi;

  assign unused_wdata_hi = ^wdata_i[DW-1:CW];

  assign pop_o = req_i && !we_i && (addr_i == OFS_DATA) && !flags_i.empty;

  always_comb begin
    status                    = '0;
    status[ST_EMPTY]          = flags_i.empty;
    status[ST_FULL]           = flags_i.full;
    status[ST_AEMPTY]         = flags_i.aempty;
    status[ST_AFULL]          = flags_i.afull;
    status[ST_CNT_LSB +: CW]  = count_i;
  end

  always_comb begin
    nx_err  = 1'b0;
    nx_data = '0;
    unique case (addr_i)
      OFS_DATA: begin
        if (we_i || flags_i.empty) nx_err = 1'b1;
        else                       nx_data = head_i;
      end
      OFS_AF:   if (!we_i) nx_data = DW'(af_q);
      OFS_AE:   if (!we_i) nx_data = DW'(ae_q);
      OFS_STAT: if (!we_i) nx_data = status;
      default:  nx_err = 1'b1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      af_q <= CW'(DEPTH);
      ae_q <= '0;
    end else if (req_i && we_i) begin
      if (addr_i == OFS_AF) af_q <= wdata_i[CW-1:0];
      if (addr_i == OFS_AE) ae_q <= wdata_i[CW-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_q   <= 1'b0;
      err_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      rsp_q   <= req_i;
      err_q   <= req_i && nx_err;
      rdata_q <= req_i ? nx_data : '0;
    end
  end

  assign af_thr_o = af_q;
  assign ae_thr_o = ae_q;
  assign rsp_o    = rsp_q;
  assign err_o    = err_q;
  assign rdata_o  = rdata_q;
endmodule

// File: rtl/hwsw_fifo.sv
module hwsw_fifo
  import hwsw_fifo_pkg::*;
#(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned DEPTH_LOG2 = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  push_valid_i,
  input  logic [DATA_W-1:0]     push_data_i,
  output logic                  overflow_o,
  output logic                  full_o,
  output logic                  empty_o,
  output logic                  almost_full_o,
  output logic                  almost_empty_o,
  output logic [DEPTH_LOG2:0]   count_o,
  input  logic                  bus_req_i,
  input  logic                  bus_we_i,
  input  logic [3:0]            bus_addr_i,
  input  logic [DATA_W-1:0]     bus_wdata_i,
  output logic                  bus_rsp_o,
  output logic                  bus_err_o,
  output logic [DATA_W-1:0]     bus_rdata_o
);
  localparam int unsigned CW = DEPTH_LOG2 + 1;

  occ_flags_t        flags;
  logic [CW-1:0]     count, af_thr, ae_thr;
  logic [DATA_W-1:0] head;
  logic              push_ok, pop_ok;
  logic              overflow_q;

  // a push at full is dropped even if a pop frees a slot this cycle
  assign push_ok = push_valid_i && !flags.full;

  hwsw_fifo_store #(.DW(DATA_W), .AW(DEPTH_LOG2)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (push_ok),
    .wr_data_i (push_data_i),
    .rd_en_i   (pop_ok),
    .head_o    (head)
  );

  hwsw_fifo_occupancy #(.AW(DEPTH_LOG2)) u_occ (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .push_i   (push_ok),
    .pop_i    (pop_ok),
    .af_thr_i (af_thr),
    .ae_thr_i (ae_thr),
    .count_o  (count),
    .flags_o  (flags)
  );

  hwsw_fifo_regs #(.DW(DATA_W), .AW(DEPTH_LOG2)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (bus_req_i),
    .we_i     (bus_we_i),
    .addr_i   (bus_addr_i),
    .wdata_i  (bus_wdata_i),
    .flags_i  (flags),
    .count_i  (count),
    .head_i   (head),
    .pop_o    (pop_ok),
    .af_thr_o (af_thr),
    .ae_thr_o (ae_thr),
    .rsp_o    (bus_rsp_o),
    .err_o    (bus_err_o),
    .rdata_o  (bus_rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) overflow_q <= 1'b0;
    else         overflow_q <= push_valid_i && flags.full;
  end

  assign overflow_o     = overflow_q;
  assign full_o         = flags.full;
  assign empty_o        = flags.empty;
  assign almost_full_o  = flags.afull;
  assign almost_empty_o = flags.aempty;
  assign count_o        = count;
endmodule

// File: rtl/hwsw_fifo_chk.sv
module hwsw_fifo_chk #(
  parameter int unsigned DEPTH_LOG2 = 4
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                push_valid_i,
  input logic                overflow_o,
  input logic                full_o,
  input logic                empty_o,
  input logic [DEPTH_LOG2:0] count_o,
  input logic                bus_req_i,
  input logic                bus_we_i,
  input logic [3:0]          bus_addr_i,
  input logic                bus_rsp_o,
  input logic                bus_err_o
);
  localparam int unsigned DEPTH = 1 << DEPTH_LOG2;

  logic rd_data;
  assign rd_data = bus_req_i && !bus_we_i && (bus_addr_i == 4'h0);

  a_r1_full_empty_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(full_o && empty_o));

  a_r1_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= (DEPTH_LOG2+1)'(DEPTH));

  a_r3_overflow_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_valid_i && full_o) |=> overflow_o);

  a_r3_no_spurious_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(push_valid_i && full_o)) |=> !overflow_o);

  a_r3_full_pinned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && !rd_data) |=> full_o);

  a_r4_balanced: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_valid_i && !full_o && rd_data && !empty_o) |=> $stable(count_o));

  a_r7_pop_ok: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data && !empty_o) |=> (bus_rsp_o && !bus_err_o));

  a_r8_empty_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data && empty_o) |=> (bus_rsp_o && bus_err_o));

  a_r10_rsp_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_i |=> bus_rsp_o);

  a_r10_no_stray_rsp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_req_i |=> !bus_rsp_o);
endmodule

bind hwsw_fifo hwsw_fifo_chk #(.DEPTH_LOG2(DEPTH_LOG2)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .push_valid_i (push_valid_i),
  .overflow_o   (overflow_o),
  .full_o       (full_o),
  .empty_o      (empty_o),
  .count_o      (count_o),
  .bus_req_i    (bus_req_i),
  .bus_we_i     (bus_we_i),
  .bus_addr_i   (bus_addr_i),
  .bus_rsp_o    (bus_rsp_o),
  .bus_err_o    (bus_err_o)
);

// File: tb/hwsw_fifo_tb_top.sv
module hwsw_fifo_tb_top;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned DW = 32;
  localparam int unsigned AW = 4;
  localparam int unsigned DEPTH = 1 << AW;

  typedef struct packed {
    logic          push;
    logic [DW-1:0] pdata;
    logic          req;
    logic          we;
    logic [3:0]    addr;
    logic [DW-1:0] wdata;
    logic          e_rsp;
    logic          e_err;
    logic [DW-1:0] e_rdata;
    logic [AW:0]   e_cnt;
    logic [3:0]    e_fl;   // {afull, aempty, full, empty}
    logic [7:0]    rq;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 32'h0,  1'b1, 1'b0, 4'h0, 32'h0,    1'b1, 1'b1, 32'h0,   5'd0, 4'b0101, 8'd8},  // R8
    '{1'b0, 32'h0,  1'b1, 1'b1, 4'h4, 32'h3,    1'b1, 1'b0, 32'h0,   5'd0, 4'b0101, 8'd5},  // R5
    '{1'b0, 32'h0,  1'b1, 1'b1, 4'h8, 32'h1,    1'b1, 1'b0, 32'h0,   5'd0, 4'b0101, 8'd6},  // R6
    '{1'b1, 32'hA1, 1'b0, 1'b0, 4'h0, 32'h0,    1'b0, 1'b0, 32'h0,   5'd1, 4'b0100, 8'd6},  // R6 boundary
    '{1'b1, 32'hA2, 1'b0, 1'b0, 4'h0, 32'h0,    1'b0, 1'b0, 32'h0,   5'd2, 4'b0000, 8'd6},  // R6
    '{1'b1, 32'hA3, 1'b0, 1'b0, 4'h0, 32'h0,    1'b0, 1'b0, 32'h0,   5'd3, 4'b1000, 8'd5},  // R5 boundary
    '{1'b1, 32'hA4, 1'b1, 1'b0, 4'h0, 32'h0,    1'b1, 1'b0, 32'hA1,  5'd3, 4'b1000, 8'd4},  // R4
    '{1'b0, 32'h0,  1'b1, 1'b0, 4'hC, 32'h0,    1'b1, 1'b0, 32'h308, 5'd3, 4'b1000, 8'd9},  // R9
    '{1'b0, 32'h0,  1'b1, 1'b0, 4'h0, 32'h0,    1'b1, 1'b0, 32'hA2,  5'd2, 4'b0000, 8'd7},  // R7
    '{1'b0, 32'h0,  1'b1, 1'b0, 4'h4, 32'h0,    1'b1, 1'b0, 32'h3,   5'd2, 4'b0000, 8'd9},  // R9
    '{1'b0, 32'h0,  1'b1, 1'b1, 4'h0, 32'h77,   1'b1, 1'b1, 32'h0,   5'd2, 4'b0000, 8'd10}, // R10
    '{1'b0, 32'h0,  1'b1, 1'b1, 4'hC, 32'hFFFF, 1'b1, 1'b0, 32'h0,   5'd2, 4'b0000, 8'd10}, // R10
    '{1'b0, 32'h0,  1'b1, 1'b0, 4'h2, 32'h0,    1'b1, 1'b1, 32'h0,   5'd2, 4'b0000, 8'd10}, // R10
    '{1'b0, 32'h0,  1'b1, 1'b0, 4'h0, 32'h0,    1'b1, 1'b0, 32'hA3,  5'd1, 4'b0100, 8'd2},  // R2
    '{1'b0, 32'h0,  1'b1, 1'b0, 4'h0, 32'h0,    1'b1, 1'b0, 32'hA4,  5'd0, 4'b0101, 8'd2},  // R2
    '{1'b0, 32'h0,  1'b1, 1'b0, 4'h0, 32'h0,    1'b1, 1'b1, 32'h0,   5'd0, 4'b0101, 8'd8},  // R8
    '{1'b0, 32'h0,  1'b1, 1'b0, 4'h8, 32'h0,    1'b1, 1'b0, 32'h1,   5'd0, 4'b0101, 8'd9}   // R9
  };

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          push_valid_i = 1'b0;
  logic [DW-1:0] push_data_i = '0;
  logic          overflow_o, full_o, empty_o, almost_full_o, almost_empty_o;
  logic [AW:0]   count_o;
  logic          bus_req_i = 1'b0;
  logic          bus_we_i = 1'b0;
  logic [3:0]    bus_addr_i = '0;
  logic [DW-1:0] bus_wdata_i = '0;
  logic          bus_rsp_o, bus_err_o;
  logic [DW-1:0] bus_rdata_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  hwsw_fifo #(.DATA_W(DW), .DEPTH_LOG2(AW)) dut_i (.*);

  task automatic check(input string rq, input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic drive(input logic push, input logic [DW-1:0] pd, input logic req,
                       input logic we, input logic [3:0] addr, input logic [DW-1:0] wd);
    push_valid_i = push; push_data_i = pd;
    bus_req_i = req; bus_we_i = we; bus_addr_i = addr; bus_wdata_i = wd;
    @(negedge clk_i);
  endtask

  task automatic idle();
    drive(1'b0, '0, 1'b0, 1'b0, 4'h0, '0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_tests++; n_fail++;
    $display("FAIL R10 watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    check("R1", "reset count", DW'(count_o), '0);
    check("R1", "reset empty", DW'(empty_o), 1);
    check("R1", "reset full",  DW'(full_o), 0);
    check("R6", "reset aempty", DW'(almost_empty_o), 1);
    check("R5", "reset afull",  DW'(almost_full_o), 0);
    check("R3", "reset overflow", DW'(overflow_o), 0);

    for (int i = 0; i < NV; i++) begin
      string rq;
      rq = $sformatf("R%0d", VEC[i].rq);
      drive(VEC[i].push, VEC[i].pdata, VEC[i].req, VEC[i].we, VEC[i].addr, VEC[i].wdata);
      check(rq, $sformatf("v%0d rsp", i), DW'(bus_rsp_o), DW'(VEC[i].e_rsp));
      if (VEC[i].e_rsp) begin
        check(rq, $sformatf("v%0d err", i), DW'(bus_err_o), DW'(VEC[i].e_err));
        check(rq, $sformatf("v%0d rdata", i), bus_rdata_o, VEC[i].e_rdata);
      end
      check(rq, $sformatf("v%0d count", i), DW'(count_o), DW'(VEC[i].e_cnt));
      check(rq, $sformatf("v%0d flags", i),
            DW'({almost_full_o, almost_empty_o, full_o, empty_o}), DW'(VEC[i].e_fl));
    end

    // R1 R2 fill to full (thresholds now af=3, ae=1)
    for (int i = 0; i < DEPTH; i++) drive(1'b1, DW'(32'h100 + i), 1'b0, 1'b0, 4'h0, '0);
    check("R1", "full count", DW'(count_o), DEPTH);
    check("R1", "full flag",  DW'(full_o), 1);
    check("R5", "afull at full", DW'(almost_full_o), 1);
    check("R3", "no overflow yet", DW'(overflow_o), 0);

    // R3 push at full is dropped
    drive(1'b1, 32'hDEAD, 1'b0, 1'b0, 4'h0, '0);
    check("R3", "overflow pulse", DW'(overflow_o), 1);
    check("R3", "count pinned", DW'(count_o), DEPTH);
    idle();
    check("R3", "overflow one cycle", DW'(overflow_o), 0);

    // R4 push and pop at full: pop proceeds, push dropped
    drive(1'b1, 32'hBEEF, 1'b1, 1'b0, 4'h0, '0);
    check("R4", "pop at full data", bus_rdata_o, 32'h100);
    check("R4", "count after pop at full", DW'(count_o), DEPTH - 1);
    check("R4", "overflow on dropped push", DW'(overflow_o), 1);

    // R2 R3 drain: order kept, no dropped word stored
    for (int i = 1; i < DEPTH; i++) begin
      drive(1'b0, '0, 1'b1, 1'b0, 4'h0, '0);
      check("R2", "drain order", bus_rdata_o, DW'(32'h100 + i));
    end
    check("R3", "empty after drain", DW'(empty_o), 1);

    // R4 simultaneous push and pop mid-range
    drive(1'b1, 32'h55, 1'b0, 1'b0, 4'h0, '0);
    drive(1'b1, 32'h66, 1'b1, 1'b0, 4'h0, '0);
    check("R4", "balanced data", bus_rdata_o, 32'h55);
    check("R4", "balanced count", DW'(count_o), 1);
    drive(1'b0, '0, 1'b1, 1'b0, 4'h0, '0);
    check("R7", "last word", bus_rdata_o, 32'h66);
    check("R7", "last word err", DW'(bus_err_o), 0);

    // R8 empty read with concurrent push: error, push still lands
    drive(1'b1, 32'h77, 1'b1, 1'b0, 4'h0, '0);
    check("R8", "empty read err", DW'(bus_err_o), 1);
    check("R8", "empty read data", bus_rdata_o, 0);
    check("R8", "push kept", DW'(count_o), 1);
    idle();
    check("R10", "rsp single cycle", DW'(bus_rsp_o), 0);

    finish_run();
  end
endmodule